// File: doc/BRIEF.md
# Two-Format Microword Decoder

This block is a purely combinational decoder for a 16-bit microinstruction word. It splits the word into the control lines of a small datapath whose registers are selected with 3-bit indices. The outputs are the register that drives the address bus, the register that drives the data bus, the registers that capture the function-unit result and the data bus, the carry-in, a 3-bit plane-select condition, the choice between the adder and the boolean result, and the four-entry boolean truth table.

Two word formats share the source fields. In the transfer format the condition and the truth table are single bits. The decoder widens them so that one function unit and one condition selector serve both formats unchanged. Index 7 (`111`) stands for external memory and index 6 (`110`) is a dummy sink. The decoder therefore also raises memory read and write strobes and drops register writes aimed at the sink.

Top module: `mcd_decoder`

## Requirements
- R1: Bit 15 selects the format. 0 is the transfer format and 1 is the function format, and `is_func` equals bit 15.
- R2: In both formats `addr_src` is bits [14:12] and `data_src` is bits [10:8].
- R3: In both formats `carry_in` is bit 11, passed through unchanged.
- R4: In the transfer format, `cond` is bit 7 copied to all three bits: 000 means stay in plane and 111 means data-zero.
- R5: In the transfer format, `use_bool` is 0 (adder selected), and `truth` is bit 3 copied to all four bits (0000 or 1111).
- R6: In the transfer format, `addr_dst` is bits [6:4] and `data_dst` is bits [2:0].
- R7: In the function format, `cond` is bits [7:5], `use_bool` is bit 4 (1 = boolean, 0 = adder) and `truth` is bits [3:0].
- R8: In the function format, `addr_dst` equals `addr_src`, `data_dst` reads 110 and `data_we` is 0.
- R9: `addr_we` is 1 in every word unless `addr_dst` is the sink index 110.
- R10: In the transfer format, `data_we` is 1 unless bits [2:0] are 110 (sink) or 111 (memory).
- R11: `mem_rd` is 1 exactly when `data_src` is 111, in either format.
- R12: `mem_wr` is 1 exactly when the word is in the transfer format and bits [2:0] are 111. It is never raised in the function format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Microinstruction word |
| is_func | output | 1 | 1 for the function format |
| addr_src | output | 3 | Register driving the address bus |
| data_src | output | 3 | Register driving the data bus |
| addr_dst | output | 3 | Register capturing the function result |
| addr_we | output | 1 | Write enable for addr_dst |
| data_dst | output | 3 | Register capturing the data bus |
| data_we | output | 1 | Register-file write enable for data_dst |
| carry_in | output | 1 | Adder / shift carry-in |
| cond | output | 3 | Plane-select condition code |
| use_bool | output | 1 | 1 selects the boolean result, 0 the adder |
| truth | output | 4 | Boolean truth table |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
A memory read and a memory write can fall on the same word. This happens in a transfer word whose data source and data destination are both 111, a memory-to-memory copy. The bench applies such a word and requires both strobes high together, with the register write enable low and the address write untouched. A second collision happens when a function word carries 111 in its low bits: there it must not be taken as a memory write, even while its data source raises a read.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int WORD_W = 16;
    localparam int REG_W  = 3;
    localparam int COND_W = 3;
    localparam int TT_W   = 4;

    localparam int FMT_BIT   = 15;
    localparam int ASRC_LSB  = 12;
    localparam int CIN_BIT   = 11;
    localparam int DSRC_LSB  = 8;

    typedef struct packed {
        logic [REG_W-1:0]  a_src;
        logic [REG_W-1:0]  d_src;
        logic [REG_W-1:0]  a_dst;
        logic [REG_W-1:0]  d_dst;
        logic              d_dst_valid;
        logic              cin;
        logic [COND_W-1:0] cond;
        logic              sel_bool;
        logic [TT_W-1:0]   tt;
    } uop_t;
endpackage

// File: rtl/mcd_move_unpack.sv
module mcd_move_unpack
    import mcd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output uop_t              uop
);
    logic [COND_W-1:0] cond_wide;
    logic [TT_W-1:0]   tt_wide;

    // Single-bit fields widened so the shared condition and function logic fit.
    for (genvar i = 0; i < COND_W; i++) begin : g_cond
        assign cond_wide[i] = word[7];
    end
    for (genvar j = 0; j < TT_W; j++) begin : g_tt
        assign tt_wide[j] = word[3];
    end

    always_comb begin
        uop             = '0;
        uop.a_src       = word[ASRC_LSB +: REG_W];
        uop.d_src       = word[DSRC_LSB +: REG_W];
        uop.cin         = word[CIN_BIT];
        uop.a_dst       = word[6:4];
        uop.d_dst       = word[2:0];
        uop.d_dst_valid = 1'b1;
        uop.cond        = cond_wide;
        uop.sel_bool    = 1'b0;
        uop.tt          = tt_wide;
    end
endmodule

// File: rtl/mcd_func_unpack.sv
module mcd_func_unpack
    import mcd_pkg::*;
#(
    parameter logic [REG_W-1:0] SINK_IDX = 3'b110
)(
    input  logic [WORD_W-1:0] word,
    output uop_t              uop
);
    always_comb begin
        uop             = '0;
        uop.a_src       = word[ASRC_LSB +: REG_W];
        uop.d_src       = word[DSRC_LSB +: REG_W];
        uop.cin         = word[CIN_BIT];
        uop.a_dst       = word[ASRC_LSB +: REG_W];
        uop.d_dst       = SINK_IDX;
        uop.d_dst_valid = 1'b0;
        uop.cond        = word[7:5];
        uop.sel_bool    = word[4];
        uop.tt          = word[3:0];
    end
endmodule

// File: rtl/mcd_dest_gate.sv
module mcd_dest_gate
    import mcd_pkg::*;
#(
    parameter logic [REG_W-1:0] SINK_IDX = 3'b110,
    parameter logic [REG_W-1:0] MEM_IDX  = 3'b111
)(
    input  uop_t uop,
    output logic a_we,
    output logic d_we,
    output logic rd,
    output logic wr
);
    logic d_is_mem;
    logic d_is_sink;

    always_comb begin
        d_is_mem  = (uop.d_dst == MEM_IDX);
        d_is_sink = (uop.d_dst == SINK_IDX);
        a_we      = (uop.a_dst != SINK_IDX);
        d_we      = uop.d_dst_valid && !d_is_mem && !d_is_sink;
        rd        = (uop.d_src == MEM_IDX);
        wr        = uop.d_dst_valid && d_is_mem;
    end
endmodule

// File: rtl/mcd_decoder.sv
module mcd_decoder
    import mcd_pkg::*;
#(
    parameter logic [REG_W-1:0] SINK_IDX = 3'b110,
    parameter logic [REG_W-1:0] MEM_IDX  = 3'b111
)(
    input  logic [15:0] instr,
    output logic        is_func,
    output logic [2:0]  addr_src,
    output logic [2:0]  data_src,
    output logic [2:0]  addr_dst,
    output logic        addr_we,
    output logic [2:0]  data_dst,
    output logic        data_we,
    output logic        carry_in,
    output logic [2:0]  cond,
    output logic        use_bool,
    output logic [3:0]  truth,
    output logic        mem_rd,
    output logic        mem_wr
);
    typedef enum logic {FMT_MOVE = 1'b0, FMT_FUNC = 1'b1} fmt_e;

    fmt_e fmt;
    uop_t uop_mv;
    uop_t uop_fn;
    uop_t uop_sel;

    mcd_move_unpack u_move (
        .word (instr),
        .uop  (uop_mv)
    );

    mcd_func_unpack #(.SINK_IDX(SINK_IDX)) u_func (
        .word (instr),
        .uop  (uop_fn)
    );

    always_comb begin
        fmt = fmt_e'(instr[FMT_BIT]);
        unique case (fmt)
            FMT_MOVE: uop_sel = uop_mv;
            FMT_FUNC: uop_sel = uop_fn;
            default:  uop_sel = uop_mv;
        endcase
    end

    mcd_dest_gate #(.SINK_IDX(SINK_IDX), .MEM_IDX(MEM_IDX)) u_gate (
        .uop  (uop_sel),
        .a_we (addr_we),
        .d_we (data_we),
        .rd   (mem_rd),
        .wr   (mem_wr)
    );

    always_comb begin
        is_func  = (fmt == FMT_FUNC);
        addr_src = uop_sel.a_src;
        data_src = uop_sel.d_src;
        addr_dst = uop_sel.a_dst;
        data_dst = uop_sel.d_dst;
        carry_in = uop_sel.cin;
        cond     = uop_sel.cond;
        use_bool = uop_sel.sel_bool;
        truth    = uop_sel.tt;
    end
endmodule

// File: rtl/mcd_decoder_chk.sv
module mcd_decoder_chk #(
    parameter logic [2:0] SINK_IDX = 3'b110,
    parameter logic [2:0] MEM_IDX  = 3'b111
)(
    input logic [15:0] instr,
    input logic        is_func,
    input logic [2:0]  addr_src,
    input logic [2:0]  addr_dst,
    input logic        addr_we,
    input logic [2:0]  data_dst,
    input logic        data_we,
    input logic [2:0]  cond,
    input logic [3:0]  truth,
    input logic        use_bool,
    input logic        mem_wr
);
    always_comb begin
        if (!$isunknown(instr)) begin
            a_r1_format_bit: assert (is_func == instr[15]);
            a_r9_addr_we_sink: assert (addr_we == (addr_dst != SINK_IDX));
            a_r12_no_func_write: assert (!(is_func && mem_wr));
            a_r10_no_reg_we_special: assert (!(data_we && (data_dst == SINK_IDX || data_dst == MEM_IDX)));
            a_r8_func_dest: assert (!is_func || (addr_dst == addr_src && !data_we));
            a_r4_move_cond_wide: assert (is_func || cond == 3'b000 || cond == 3'b111);
            a_r5_move_adder: assert (is_func || (!use_bool && (truth == 4'b0000 || truth == 4'b1111)));
        end
    end
endmodule

bind mcd_decoder mcd_decoder_chk #(.SINK_IDX(SINK_IDX), .MEM_IDX(MEM_IDX)) u_chk (
    .instr    (instr),
    .is_func  (is_func),
    .addr_src (addr_src),
    .addr_dst (addr_dst),
    .addr_we  (addr_we),
    .data_dst (data_dst),
    .data_we  (data_we),
    .cond     (cond),
    .truth    (truth),
    .use_bool (use_bool),
    .mem_wr   (mem_wr)
);

// File: tb/mcd_decoder_tb.sv
`timescale 1ns/1ps
module mcd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic        is_func, addr_we, data_we, carry_in, use_bool, mem_rd, mem_wr;
    logic [2:0]  addr_src, data_src, addr_dst, data_dst, cond;
    logic [3:0]  truth;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mcd_decoder u_dut (
        .instr(instr), .is_func(is_func), .addr_src(addr_src), .data_src(data_src),
        .addr_dst(addr_dst), .addr_we(addr_we), .data_dst(data_dst), .data_we(data_we),
        .carry_in(carry_in), .cond(cond), .use_bool(use_bool), .truth(truth),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] w);
        @(negedge clk);
        instr = w;
        #2;
    endtask

    task automatic t_reset;
        @(negedge clk);
        #2;
        check("R1", "reset is_func", is_func, 0);
        check("R9", "reset addr_we", addr_we, 1);
        check("R11", "reset mem_rd", mem_rd, 0);
        check("R12", "reset mem_wr", mem_wr, 0);
    endtask

    task automatic t_move_plain;
        apply(16'h1234);
        check("R1", "mv is_func", is_func, 0);
        check("R2", "mv addr_src", addr_src, 1);
        check("R2", "mv data_src", data_src, 2);
        check("R3", "mv carry_in", carry_in, 0);
        check("R4", "mv cond", cond, 0);
        check("R5", "mv truth", truth, 0);
        check("R5", "mv use_bool", use_bool, 0);
        check("R6", "mv addr_dst", addr_dst, 3);
        check("R6", "mv data_dst", data_dst, 4);
        check("R10", "mv data_we", data_we, 1);
    endtask

    task automatic t_move_ones;
        apply(16'h5BA9);
        check("R2", "mv1 addr_src", addr_src, 5);
        check("R3", "mv1 carry_in", carry_in, 1);
        check("R4", "mv1 cond", cond, 7);
        check("R5", "mv1 truth", truth, 15);
        check("R5", "mv1 use_bool", use_bool, 0);
        check("R6", "mv1 addr_dst", addr_dst, 2);
        check("R6", "mv1 data_dst", data_dst, 1);
    endtask

    task automatic t_mem_to_mem;
        apply(16'h2727);
        check("R11", "m2m mem_rd", mem_rd, 1);
        check("R12", "m2m mem_wr", mem_wr, 1);
        check("R10", "m2m data_we", data_we, 0);
        check("R9", "m2m addr_we", addr_we, 1);
    endtask

    task automatic t_sink;
        apply(16'h0166);
        check("R9", "sink addr_we", addr_we, 0);
        check("R10", "sink data_we", data_we, 0);
        check("R12", "sink mem_wr", mem_wr, 0);
        check("R11", "sink mem_rd", mem_rd, 0);
    endtask

    task automatic t_func;
        apply(16'hBCB6);
        check("R1", "fn is_func", is_func, 1);
        check("R2", "fn addr_src", addr_src, 3);
        check("R2", "fn data_src", data_src, 4);
        check("R3", "fn carry_in", carry_in, 1);
        check("R7", "fn cond", cond, 5);
        check("R7", "fn use_bool", use_bool, 1);
        check("R7", "fn truth", truth, 6);
        check("R8", "fn addr_dst", addr_dst, 3);
        check("R8", "fn data_dst", data_dst, 6);
        check("R8", "fn data_we", data_we, 0);
        check("R9", "fn addr_we", addr_we, 1);
    endtask

    task automatic t_func_mem;
        apply(16'hE74F);
        check("R8", "fnm addr_dst", addr_dst, 6);
        check("R9", "fnm addr_we", addr_we, 0);
        check("R11", "fnm mem_rd", mem_rd, 1);
        check("R12", "fnm mem_wr", mem_wr, 0);
        check("R7", "fnm cond", cond, 2);
        check("R7", "fnm use_bool", use_bool, 0);
        check("R7", "fnm truth", truth, 15);
        check("R8", "fnm data_we", data_we, 0);
    endtask

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_move_plain();
        t_move_ones();
        t_mem_to_mem();
        t_sink();
        t_func();
        t_func_mem();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule